// File: doc/BRIEF.md
# Memory-Mapped General-Purpose I/O Bank

This block gives a host a small register window onto a group of general-purpose pins. It sits on a synchronous slave bus: a two-bit word address, read and write strobes, write data, and a registered read data word. The host writes the value the pins should drive and reads back the value the pins carry. The input and output values are held in separate storage.

Build-time parameters pick the shape of the bank. `WIDTH` sets the pin count, from 1 to 32. With `TRISTATE` set, the separate input and output ports give way to one bidirectional pad bus, and a direction register decides which pads the block drives. `EDGE_MODE` turns on a sticky per-pin edge recorder that catches rising, falling or both kinds of transition. `IRQ_MODE` adds a per-pin enable register and a single interrupt line, sourced from the pin levels or from the recorded edges. All pin inputs pass through a two-flop synchroniser before anything looks at them.

Top module: `gpio_bank`

## Requirements
- R1: `WIDTH` may be 1 to 32, checked at elaboration. Every register reads back zero-extended to 32 bits. A read strobe in one cycle puts its value on `rdata_o` from the next clock edge on, and the value is held until the next read.
- R2: A write to word 0 stores the low `WIDTH` bits of write data, and without `TRISTATE` that value appears on `out_pins_o` after the clock edge that takes the write. The stored value is zero after reset.
- R3: A read of word 0 returns the pin inputs after a two-flop synchroniser, so a pin change shows in a read issued three or more cycles later.
- R4: With `TRISTATE`, inputs come from `pad_io`, and `out_pins_o` stays zero. Each bit set in the direction register (word 1, 1 = drive) makes the block drive that pad with the stored output bit. Each clear bit leaves the pad at high impedance. Direction resets to zero, so all pads are inputs.
- R5: The direction register (word 1) and the interrupt enable register (word 2) read back the value last written.
- R6: Word 3 is the edge record. One bit per pin is set by a transition between consecutive synchronised samples: a 0-to-1 transition in rising mode, 1-to-0 in falling mode, and either one in both mode. A set bit stays set until it is cleared.
- R7: Any write to word 3 clears every edge record bit whatever the data. An edge detected in the same cycle as that write still leaves its bit set.
- R8: In level interrupt mode, `irq_o` is high one cycle after any pin that is both enabled and synchronised-high, and low one cycle after none is.
- R9: In edge interrupt mode, `irq_o` is high one cycle after any edge record bit is set whose enable bit is also set. Edge interrupt mode requires edge capture; the pairing of edge interrupts with no capture is rejected at elaboration.
- R10: A register left out of the build (direction without `TRISTATE`, enable without interrupts, the edge record with capture off) reads zero and ignores writes. Without interrupts, `irq_o` stays low.
- R11: After reset, `irq_o`, the output register, the edge record and the enable register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, registered |
| in_pins_i | input | WIDTH | Pin inputs (non-tristate build) |
| out_pins_o | output | WIDTH | Pin outputs (non-tristate build) |
| pad_io | inout | WIDTH | Bidirectional pads (tristate build) |

## Verification
Four builds are tried: rising capture with edge interrupts, tristate pads with falling capture and level interrupts, both-edge capture without interrupts, and the plain default. Input patterns mix rising and falling bits within one word, so a wrong polarity selection shows up as extra or missing bits. A pin that rises and then falls separates both-edge capture from the single-polarity modes. One pattern places a new edge in exactly the cycle of a clearing write, which tells clear-wins from edge-wins. On the tristate build, pads are split between bench-driven and block-driven bits, so a read shows whether the direction register steers each bit on its own.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {EDGE_NONE, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_mode_e;
   typedef enum logic [1:0] {IRQ_OFF, IRQ_LEVEL, IRQ_EDGE} irq_mode_e;

   localparam int BUS_W = 32;
   localparam logic [1:0] WORD_DATA = 2'd0;
   localparam logic [1:0] WORD_DIR  = 2'd1;
   localparam logic [1:0] WORD_EN   = 2'd2;
   localparam logic [1:0] WORD_EDGE = 2'd3;
endpackage

// File: rtl/gpio_in_stage.sv
// Two-flop synchroniser followed by a one-sample history for edge detection.
module gpio_in_stage #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] meta_q, sync_q, hist_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         meta_q <= '0;
         sync_q <= '0;
         hist_q <= '0;
      end else begin
         meta_q <= raw_i;
         sync_q <= meta_q;
         hist_q <= sync_q;
      end
   end

   assign sync_o = sync_q;
   assign rise_o = sync_q & ~hist_q;
   assign fall_o = ~sync_q & hist_q;
endmodule

// File: rtl/gpio_edge_cap.sv
// Sticky per-pin edge record; a clear loses to an edge in the same cycle.
module gpio_edge_cap
   import gpio_pkg::*;
#(
   parameter int         WIDTH = 8,
   parameter edge_mode_e MODE  = EDGE_NONE
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] rise_i,
   input  logic [WIDTH-1:0] fall_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] hits_o,
   output logic [WIDTH-1:0] cap_o
);
   localparam bit TAKE_RISE = (MODE == EDGE_RISE) || (MODE == EDGE_BOTH);
   localparam bit TAKE_FALL = (MODE == EDGE_FALL) || (MODE == EDGE_BOTH);

   logic [WIDTH-1:0] cap_q;

   assign hits_o = (rise_i & {WIDTH{TAKE_RISE}}) | (fall_i & {WIDTH{TAKE_FALL}});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_q <= '0;
      else         cap_q <= (clr_i ? '0 : cap_q) | hits_o;
   end

   assign cap_o = cap_q;
endmodule

// File: rtl/gpio_irq_gen.sv
// Masked OR-reduction of the chosen source, registered.
module gpio_irq_gen
   import gpio_pkg::*;
#(
   parameter int        WIDTH = 8,
   parameter irq_mode_e MODE  = IRQ_LEVEL
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] en_i,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] cap_i,
   output logic             irq_o
);
   logic [WIDTH-1:0] src;
   logic             irq_q;

   assign src = (MODE == IRQ_EDGE) ? cap_i : level_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |(src & en_i);
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int         WIDTH     = 8,
   parameter bit         TRISTATE  = 1'b0,
   parameter edge_mode_e EDGE_MODE = EDGE_NONE,
   parameter irq_mode_e  IRQ_MODE  = IRQ_OFF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [WIDTH-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   output logic              irq_o,
   input  logic [WIDTH-1:0]  in_pins_i,
   output logic [WIDTH-1:0]  out_pins_o,
   inout  wire  [WIDTH-1:0]  pad_io
);
   localparam bit HAS_IRQ = (IRQ_MODE != IRQ_OFF);

   // elaboration checks
   if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
      $error("gpio_bank: WIDTH must lie in 1..32");
   end
   if (IRQ_MODE == IRQ_EDGE && EDGE_MODE == EDGE_NONE) begin : g_bad_irq
      $error("gpio_bank: edge interrupts need edge capture");
   end

   logic [WIDTH-1:0] out_q, dir_q, en_q;
   logic [WIDTH-1:0] raw, sync_w, rise_w, fall_w, hits_w, cap_w;
   logic [BUS_W-1:0] rd_mux, rdata_q;
   logic             wr_data, wr_dir, wr_en, wr_edge;

   assign wr_data = wr_i && (addr_i == WORD_DATA);
   assign wr_dir  = wr_i && (addr_i == WORD_DIR);
   assign wr_en   = wr_i && (addr_i == WORD_EN);
   assign wr_edge = wr_i && (addr_i == WORD_EDGE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      out_q <= '0;
      else if (wr_data) out_q <= wdata_i;
   end

   if (TRISTATE) begin : g_dir
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     dir_q <= '0;
         else if (wr_dir) dir_q <= wdata_i;
      end
   end else begin : g_no_dir
      assign dir_q = '0;
   end

   if (HAS_IRQ) begin : g_en
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    en_q <= '0;
         else if (wr_en) en_q <= wdata_i;
      end
   end else begin : g_no_en
      assign en_q = '0;
   end

   // pin side
   assign raw        = TRISTATE ? pad_io : in_pins_i;
   assign out_pins_o = TRISTATE ? '0 : out_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign pad_io[i] = dir_q[i] ? out_q[i] : 1'bz;
   end

   gpio_in_stage #(.WIDTH(WIDTH)) u_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw),
      .sync_o (sync_w),
      .rise_o (rise_w),
      .fall_o (fall_w)
   );

   gpio_edge_cap #(.WIDTH(WIDTH), .MODE(EDGE_MODE)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise_w),
      .fall_i (fall_w),
      .clr_i  (wr_edge),
      .hits_o (hits_w),
      .cap_o  (cap_w)
   );

   if (HAS_IRQ) begin : g_irq
      gpio_irq_gen #(.WIDTH(WIDTH), .MODE(IRQ_MODE)) u_irq (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .en_i    (en_q),
         .level_i (sync_w),
         .cap_i   (cap_w),
         .irq_o   (irq_o)
      );
   end else begin : g_no_irq
      assign irq_o = 1'b0;
   end

   // read path
   always_comb begin
      rd_mux = '0;
      unique case (addr_i)
         WORD_DATA: rd_mux[WIDTH-1:0] = sync_w;
         WORD_DIR:  rd_mux[WIDTH-1:0] = dir_q;
         WORD_EN:   rd_mux[WIDTH-1:0] = en_q;
         WORD_EDGE: rd_mux[WIDTH-1:0] = cap_w;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_mux;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_pkg::*;
#(
   parameter int         WIDTH     = 8,
   parameter bit         TRISTATE  = 1'b0,
   parameter edge_mode_e EDGE_MODE = EDGE_NONE,
   parameter irq_mode_e  IRQ_MODE  = IRQ_OFF
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [1:0]       addr_i,
   input logic             wr_i,
   input logic             rd_i,
   input logic [WIDTH-1:0] wdata_i,
   input logic [31:0]      rdata_o,
   input logic             irq_o,
   input logic [WIDTH-1:0] out_q,
   input logic [WIDTH-1:0] en_q,
   input logic [WIDTH-1:0] sync_w,
   input logic [WIDTH-1:0] hits_w,
   input logic [WIDTH-1:0] cap_w
);
   // R2
   data_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == WORD_DATA) |=> (out_q == $past(wdata_i)));

   // R6
   edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hits_w != '0) |=> ((cap_w & $past(hits_w)) == $past(hits_w)));

   // R6
   edge_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(wr_i && addr_i == WORD_EDGE) && hits_w == '0) |=> $stable(cap_w));

   // R7
   edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == WORD_EDGE) |=> (cap_w == $past(hits_w)));

   // R8
   level_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (IRQ_MODE == IRQ_LEVEL) |=> (irq_o == $past(|(en_q & sync_w))));

   // R9
   edge_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (IRQ_MODE == IRQ_EDGE) |=> (irq_o == $past(|(en_q & cap_w))));

   // R10
   no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (IRQ_MODE == IRQ_OFF) |-> !irq_o);

   // R1
   rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |=> $stable(rdata_o));
endmodule

bind gpio_bank gpio_bank_chk #(
   .WIDTH(WIDTH), .TRISTATE(TRISTATE), .EDGE_MODE(EDGE_MODE), .IRQ_MODE(IRQ_MODE)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .addr_i  (addr_i),
   .wr_i    (wr_i),
   .rd_i    (rd_i),
   .wdata_i (wdata_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .out_q   (out_q),
   .en_q    (en_q),
   .sync_w  (sync_w),
   .hits_w  (hits_w),
   .cap_w   (cap_w)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
   import gpio_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  wr_v = '0;
   logic [3:0]  rd_v = '0;
   logic [31:0] rdata [4];
   logic [3:0]  irq;
   logic [7:0]  in0 = '0;
   logic [4:0]  in2 = '0;
   logic [7:0]  in3 = '0;
   logic [7:0]  out0, out3;
   logic [3:0]  out1;
   logic [4:0]  out2;
   wire  [7:0]  pad0, pad3;
   wire  [3:0]  pad1;
   wire  [4:0]  pad2;
   logic [3:0]  pad_val = 4'h0;
   logic [3:0]  pad_en  = 4'hF;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   for (genvar i = 0; i < 4; i++) begin : g_drv
      assign pad1[i] = pad_en[i] ? pad_val[i] : 1'bz;
   end

   gpio_bank #(.WIDTH(8), .TRISTATE(1'b0), .EDGE_MODE(EDGE_RISE), .IRQ_MODE(IRQ_EDGE)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_v[0]), .rd_i(rd_v[0]),
      .wdata_i(wdata[7:0]), .rdata_o(rdata[0]), .irq_o(irq[0]),
      .in_pins_i(in0), .out_pins_o(out0), .pad_io(pad0));

   gpio_bank #(.WIDTH(4), .TRISTATE(1'b1), .EDGE_MODE(EDGE_FALL), .IRQ_MODE(IRQ_LEVEL)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_v[1]), .rd_i(rd_v[1]),
      .wdata_i(wdata[3:0]), .rdata_o(rdata[1]), .irq_o(irq[1]),
      .in_pins_i(4'hF), .out_pins_o(out1), .pad_io(pad1));

   gpio_bank #(.WIDTH(5), .TRISTATE(1'b0), .EDGE_MODE(EDGE_BOTH), .IRQ_MODE(IRQ_OFF)) u2 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_v[2]), .rd_i(rd_v[2]),
      .wdata_i(wdata[4:0]), .rdata_o(rdata[2]), .irq_o(irq[2]),
      .in_pins_i(in2), .out_pins_o(out2), .pad_io(pad2));

   gpio_bank u3 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_v[3]), .rd_i(rd_v[3]),
      .wdata_i(wdata[7:0]), .rdata_o(rdata[3]), .irq_o(irq[3]),
      .in_pins_i(in3), .out_pins_o(out3), .pad_io(pad3));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic bus_wr(input int which, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_v[which] = 1'b1;
      @(negedge clk);
      wr_v = '0;
   endtask

   task automatic bus_rd(input int which, input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_v[which] = 1'b1;
      @(negedge clk);
      rd_v = '0;
      d = rdata[which];
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R11 irq after reset", {28'd0, irq}, 32'd0);
      check("R11 outputs after reset", {24'd0, out0}, 32'd0);
      bus_rd(0, WORD_EN, v);   check("R11 enable after reset", v, 32'd0);
      bus_rd(0, WORD_EDGE, v); check("R11 edge record after reset", v, 32'd0);
   endtask

   task automatic t_data();
      logic [31:0] v;
      bus_wr(0, WORD_DATA, 32'hFFFF_FFA5);
      check("R2 output drive", {24'd0, out0}, 32'hA5);
      in0 = 8'h3C;
      bus_rd(0, WORD_DATA, v);
      check("R3 not yet through synchroniser", v, 32'h0);
      idle(3);
      bus_rd(0, WORD_DATA, v);
      check("R3 R1 input read zero-extended", v, 32'h3C);
   endtask

   task automatic t_rise();
      logic [31:0] v;
      bus_wr(0, WORD_EDGE, 32'hFF);
      bus_rd(0, WORD_EDGE, v);   check("R7 clear", v, 32'h0);
      in0 = 8'h0F; idle(4);
      bus_rd(0, WORD_EDGE, v);   check("R6 rising only", v, 32'h03);
      in0 = 8'h00; idle(4);
      bus_rd(0, WORD_EDGE, v);   check("R6 sticky, falls ignored", v, 32'h03);
   endtask

   task automatic t_edge_irq();
      logic [31:0] v;
      check("R9 masked off", {31'd0, irq[0]}, 32'd0);
      bus_wr(0, WORD_EN, 32'h02); idle(1);
      check("R9 enabled edge raises irq", {31'd0, irq[0]}, 32'd1);
      bus_rd(0, WORD_EN, v);     check("R5 enable readback", v, 32'h02);
      bus_wr(0, WORD_EN, 32'h40); idle(1);
      check("R9 other bit enabled", {31'd0, irq[0]}, 32'd0);
      bus_wr(0, WORD_EN, 32'h01); idle(1);
      check("R9 bit0 enabled", {31'd0, irq[0]}, 32'd1);
      bus_wr(0, WORD_EDGE, 32'h0); idle(1);
      check("R9 clear drops irq", {31'd0, irq[0]}, 32'd0);
      bus_wr(0, WORD_EN, 32'h00);
      bus_wr(0, WORD_DIR, 32'hFF);
      bus_rd(0, WORD_DIR, v);    check("R10 absent direction reads zero", v, 32'h0);
      check("R10 output unchanged", {24'd0, out0}, 32'hA5);
   endtask

   task automatic t_same_cycle();
      logic [31:0] v;
      in0 = 8'h10; idle(4);
      @(negedge clk); in0 = 8'h90;
      @(negedge clk);
      @(negedge clk); addr = WORD_EDGE; wdata = '0; wr_v[0] = 1'b1;
      @(negedge clk); wr_v = '0;
      bus_rd(0, WORD_EDGE, v);
      check("R7 edge wins over clear", v, 32'h80);
   endtask

   task automatic t_tristate();
      logic [31:0] v;
      pad_val = 4'hA; pad_en = 4'hF; idle(4);
      bus_rd(1, WORD_DATA, v);   check("R4 pad input", v, 32'hA);
      bus_wr(1, WORD_DATA, 32'h5);
      check("R4 out_pins stay zero", {28'd0, out1}, 32'd0);
      pad_en = 4'hC;
      bus_wr(1, WORD_DIR, 32'h3);
      check("R4 pads driven per direction", {28'd0, pad1}, 32'h9);
      idle(3);
      bus_rd(1, WORD_DATA, v);   check("R4 mixed read", v, 32'h9);
      bus_rd(1, WORD_DIR, v);    check("R5 direction readback", v, 32'h3);
      bus_wr(1, WORD_EDGE, 32'h0);
      pad_val = 4'h2; idle(4);
      bus_rd(1, WORD_EDGE, v);   check("R6 falling only", v, 32'h8);
      bus_wr(1, WORD_EN, 32'h4); idle(1);
      check("R8 enabled pin low", {31'd0, irq[1]}, 32'd0);
      pad_val = 4'h6; idle(4);
      check("R8 enabled pin high", {31'd0, irq[1]}, 32'd1);
      bus_wr(1, WORD_EN, 32'h0); idle(1);
      check("R8 disabled", {31'd0, irq[1]}, 32'd0);
   endtask

   task automatic t_both();
      logic [31:0] v;
      bus_wr(2, WORD_EDGE, 32'h0);
      in2 = 5'h11; idle(4);
      in2 = 5'h01; idle(4);
      bus_rd(2, WORD_EDGE, v);   check("R6 both polarities", v, 32'h11);
      bus_wr(2, WORD_EDGE, 32'h0);
      bus_rd(2, WORD_EDGE, v);   check("R7 clear with zero data", v, 32'h0);
      bus_wr(2, WORD_EN, 32'h1F);
      bus_rd(2, WORD_EN, v);     check("R10 absent enable reads zero", v, 32'h0);
      check("R10 no interrupt build", {31'd0, irq[2]}, 32'd0);
   endtask

   task automatic t_plain();
      logic [31:0] v;
      in3 = 8'hFF; idle(4);
      in3 = 8'h00; idle(4);
      bus_rd(3, WORD_EDGE, v);   check("R10 no capture reads zero", v, 32'h0);
      bus_rd(3, WORD_DATA, v);   check("R3 default build input", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data();
      t_rise();
      t_edge_irq();
      t_same_cycle();
      t_tristate();
      t_both();
      t_plain();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule